// File: doc/BRIEF.md
# Multi-link frame sync generator

This block watches the vertical sync lines of several camera links that share one pixel clock. It produces a single frame sync pulse that the cameras use to start their next frame, so that all of them stay aligned. A link-enable mask picks which links take part. A single enabled bit makes that link the master. Several bits let the block follow whichever enabled link is slowest in each frame.

A rising edge on any enabled link opens a round, and the round closes once every enabled link has shown its rising edge. Either the opening edge or the closing edge becomes the reference for the pulse, chosen by a mode input. A positive margin places the pulse a set number of cycles after the reference. A negative margin places it that many cycles before the next expected reference, using the measured spacing between references. A divider lets the block emit one pulse for every N+1 references.

While a round is open, the block measures the distance between its first and last edge. If that distance exceeds a programmable threshold, it raises a sticky error flag and counts the event in a saturating counter. A threshold of zero turns the check off.

Top module: `fsg_top`

## Requirements
- R1: Only links whose bit in `link_en` is 1 take part. Edges on other links change neither the pulse timing nor the skew check.
- R2: With `wait_all` = 1, the reference is the edge that completes the round, which is the last rising edge among the enabled links.
- R3: With `wait_all` = 0, the reference is the first rising edge of the round among the enabled links.
- R4: With `margin_neg` = 0, `fsync` is high in the cycle that follows clock edge t+`margin`. Here t is the clock edge that first samples the reference link high after it was low.
- R5: With `margin_neg` = 1, the delay after edge t is P−`margin`, or 0 if `margin` ≥ P. P is the number of clock edges since the previous reference. No pulse is made for the first reference after reset.
- R6: `period_div` = N gives one pulse for every N+1 references. The pulse comes on the (N+1)-th reference after reset and then on every (N+1)-th one after that. N = 0 gives a pulse on every reference.
- R7: The skew of a round is the number of clock edges from its first to its last enabled rising edge. When `skew_thr` is nonzero and the skew is greater than `skew_thr`, `skew_err` goes to 1 and stays there until reset, and `skew_cnt` increments.
- R8: When `skew_thr` is 0, `skew_err` and `skew_cnt` never change.
- R9: `skew_cnt` stops at 255.
- R10: After reset, `fsync`, `skew_err` and `skew_cnt` are 0.
- R11: `fsync` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock shared by all links |
| rst_n | input | 1 | Asynchronous active-low reset |
| vs_in | input | NLINK | Vertical sync of each link, active-high rising edge |
| link_en | input | NLINK | Links that take part in the round |
| wait_all | input | 1 | 1: reference is the last link edge; 0: reference is the first link edge |
| period_div | input | 4 | References per pulse, minus one |
| margin | input | 13 | Margin magnitude in clock cycles |
| margin_neg | input | 1 | 1: pulse comes before the next expected reference |
| skew_thr | input | 13 | Allowed skew in clock cycles, 0 turns the check off |
| fsync | output | 1 | Frame sync pulse |
| skew_err | output | 1 | Sticky skew violation flag |
| skew_cnt | output | 8 | Saturating count of skew violations |

## Verification
The assertions assume that each enabled link stays low for at least one cycle between rising edges, so that two references never fall on adjacent edges. They also assume the configuration inputs are held steady while the block runs, and that any margin is smaller than the spacing between references, so a pending pulse is never reloaded before it fires. The stimulus meets these assumptions. It sets every configuration input while reset is held. It gives every link a two-cycle high pulse at a fixed offset inside each frame, with frames longer than the largest offset plus three. It keeps margins below the frame length, except in the one case that checks the clamp to zero.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int VALW = 13;
  localparam int DIVW = 4;
  localparam int ERRW = 8;
  typedef logic [VALW-1:0] val_t;
endpackage

// File: rtl/fsg_link_track.sv
module fsg_link_track
  import fsg_pkg::*;
#(
  parameter int NLINK = 4,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINK-1:0] vs_in,
  input  logic [NLINK-1:0] link_en,
  input  val_t             skew_thr,
  output logic             start_ev,
  output logic             done_ev,
  output logic             skew_hit
);
  logic [NLINK-1:0] vs_q, seen_q, seen_d, rise, merged;
  logic             act_q, act_d;
  logic [CW-1:0]    gap_q, gap_d, gap_used;

  assign rise   = vs_in & ~vs_q & link_en;
  assign merged = (seen_q | rise) & link_en;

  always_comb begin
    seen_d   = seen_q;
    act_d    = act_q;
    gap_d    = gap_q;
    gap_used = '0;
    start_ev = 1'b0;
    done_ev  = 1'b0;
    if (!act_q) begin
      if (|rise) begin
        start_ev = 1'b1;
        if (rise == link_en) begin
          done_ev = 1'b1;
        end else begin
          act_d  = 1'b1;
          seen_d = rise;
          gap_d  = {{(CW-1){1'b0}}, 1'b1};
        end
      end
    end else begin
      gap_used = gap_q;
      if (merged == link_en) begin
        done_ev = 1'b1;
        act_d   = 1'b0;
        seen_d  = '0;
      end else begin
        seen_d = merged;
        gap_d  = (gap_q == '1) ? gap_q : gap_q + 1'b1;
      end
    end
    skew_hit = done_ev && (skew_thr != '0) &&
               (gap_used > {{(CW-VALW){1'b0}}, skew_thr});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q   <= '0;
      seen_q <= '0;
      act_q  <= 1'b0;
      gap_q  <= '0;
    end else begin
      vs_q   <= vs_in;
      seen_q <= seen_d;
      act_q  <= act_d;
      gap_q  <= gap_d;
    end
  end

  // A round that has just completed cannot be completed again on the next edge
  assert_round_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && done_ev) |=> !act_q);
endmodule

// File: rtl/fsg_sched.sv
module fsg_sched
  import fsg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_ev,
  input  logic [DIVW-1:0] period_div,
  input  val_t            margin,
  input  logic            margin_neg,
  output logic            fsync
);
  logic [DIVW-1:0] div_q, div_d;
  logic [CW-1:0]   per_q, per_d, tmr_q, tmr_d, mx;
  logic            have_q, have_d, pend_q, pend_d;

  assign mx    = {{(CW-VALW){1'b0}}, margin};
  assign fsync = pend_q && (tmr_q == '0);

  always_comb begin
    per_d  = (per_q == '1) ? per_q : per_q + 1'b1;
    have_d = have_q;
    div_d  = div_q;
    pend_d = pend_q;
    tmr_d  = tmr_q;
    if (fsync) pend_d = 1'b0;
    else if (pend_q) tmr_d = tmr_q - 1'b1;
    if (ref_ev) begin
      per_d  = {{(CW-1){1'b0}}, 1'b1};
      have_d = 1'b1;
      if (div_q >= period_div) begin
        div_d = '0;
        if (!margin_neg) begin
          pend_d = 1'b1;
          tmr_d  = mx;
        end else if (have_q) begin
          pend_d = 1'b1;
          tmr_d  = (per_q > mx) ? per_q - mx : '0;
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      per_q  <= '0;
      tmr_q  <= '0;
      have_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      per_q  <= per_d;
      tmr_q  <= tmr_d;
      have_q <= have_d;
      pend_q <= pend_d;
    end
  end

  assert_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> !fsync);
  assert_pending_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && tmr_q != '0) |=> pend_q);
endmodule

// File: rtl/fsg_top.sv
module fsg_top
  import fsg_pkg::*;
#(
  parameter int NLINK = 4,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINK-1:0] vs_in,
  input  logic [NLINK-1:0] link_en,
  input  logic             wait_all,
  input  logic [DIVW-1:0]  period_div,
  input  logic [VALW-1:0]  margin,
  input  logic             margin_neg,
  input  logic [VALW-1:0]  skew_thr,
  output logic             fsync,
  output logic             skew_err,
  output logic [ERRW-1:0]  skew_cnt
);
  logic [1:0]      rsync_q;
  logic            rst_sn, start_ev, done_ev, skew_hit, ref_ev;
  logic            err_d;
  logic [ERRW-1:0] cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  fsg_link_track #(.NLINK(NLINK), .CW(CW)) u_track (
    .clk(clk), .rst_n(rst_sn), .vs_in(vs_in), .link_en(link_en),
    .skew_thr(skew_thr), .start_ev(start_ev), .done_ev(done_ev),
    .skew_hit(skew_hit));

  assign ref_ev = wait_all ? done_ev : start_ev;

  fsg_sched #(.CW(CW)) u_sched (
    .clk(clk), .rst_n(rst_sn), .ref_ev(ref_ev), .period_div(period_div),
    .margin(margin), .margin_neg(margin_neg), .fsync(fsync));

  always_comb begin
    err_d = skew_err;
    cnt_d = skew_cnt;
    if (skew_hit) begin
      err_d = 1'b1;
      if (skew_cnt != '1) cnt_d = skew_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      skew_err <= 1'b0;
      skew_cnt <= '0;
    end else begin
      skew_err <= err_d;
      skew_cnt <= cnt_d;
    end
  end

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    skew_err |=> skew_err);
  assert_thr_off_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (skew_thr == '0) |=> $stable(skew_cnt));
  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (skew_cnt == '1) |=> (skew_cnt == '1));
  assert_cnt_flag_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (skew_cnt != '0) |-> skew_err);
endmodule

// File: tb/fsg_top_tb.sv
module fsg_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  vs_in, link_en;
  logic        wait_all, margin_neg;
  logic [3:0]  period_div;
  logic [12:0] margin, skew_thr;
  logic        fsync, skew_err;
  logic [7:0]  skew_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit exp_fs [8192];

  always #2 clk = ~clk;

  fsg_top u_dut (
    .clk(clk), .rst_n(rst_n), .vs_in(vs_in), .link_en(link_en),
    .wait_all(wait_all), .period_div(period_div), .margin(margin),
    .margin_neg(margin_neg), .skew_thr(skew_thr), .fsync(fsync),
    .skew_err(skew_err), .skew_cnt(skew_cnt));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic scenario(input string tag, input logic [3:0] en,
                          input int o0, input int o1, input int o2, input int o3,
                          input int flen, input int nfr, input bit wall,
                          input int m, input bit neg, input int dv, input int thr);
    int offs[4];
    int lo, hi, gap, total, nerr;
    offs[0] = o0; offs[1] = o1; offs[2] = o2; offs[3] = o3;
    lo = 1000; hi = -1;
    for (int k = 0; k < 4; k++)
      if (en[k]) begin
        if (offs[k] < lo) lo = offs[k];
        if (offs[k] > hi) hi = offs[k];
      end
    gap   = hi - lo;
    total = nfr * flen + flen + m + 8;
    for (int i = 0; i < 8192; i++) exp_fs[i] = 1'b0;
    for (int f = 0; f < nfr; f++) begin
      int t, d;
      t = f * flen + 2 + (wall ? hi : lo);
      if (f % (dv + 1) == dv) begin
        if (!neg) exp_fs[t + m + 1] = 1'b1;
        else if (f > 0) begin
          d = (flen > m) ? flen - m : 0;
          exp_fs[t + d + 1] = 1'b1;
        end
      end
    end
    @(negedge clk);
    rst_n = 1'b0; vs_in = '0; link_en = en; wait_all = wall;
    margin = 13'(m); margin_neg = neg; period_div = 4'(dv); skew_thr = 13'(thr);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: outputs at rest after reset
    chk({tag, " R10 fsync"}, int'(fsync), 0);
    chk({tag, " R10 skew_err"}, int'(skew_err), 0);
    chk({tag, " R10 skew_cnt"}, int'(skew_cnt), 0);
    for (int i = 0; i < total; i++) begin
      if (exp_fs[i] || fsync) chk({tag, " fsync timing"}, int'(fsync), int'(exp_fs[i]));
      for (int k = 0; k < 4; k++) begin
        int f, r;
        f = (i - 2) / flen; r = (i - 2) % flen;
        vs_in[k] = (i >= 2) && (f < nfr) && (r == offs[k] || r == offs[k] + 1);
      end
      @(negedge clk);
    end
    nerr = (thr != 0 && gap > thr) ? nfr : 0;
    if (nerr > 255) nerr = 255;
    // R7 R8 R9: error flag and count after the run
    chk({tag, " R7 skew_err"}, int'(skew_err), (nerr > 0) ? 1 : 0);
    chk({tag, " R9 skew_cnt"}, int'(skew_cnt), nerr);
  endtask

  initial begin
    rst_n = 1'b0; vs_in = '0; link_en = '0; wait_all = 1'b0;
    margin = '0; margin_neg = 1'b0; period_div = '0; skew_thr = '0;
    // R2 R4: slowest link as reference, sweep of positive margins
    for (int m = 0; m < 6; m++)
      scenario("R2 R4 last-edge", 4'b1111, 0, 3, 5, 2, 16, 3, 1'b1, m, 1'b0, 0, 0);
    // R3 R4: first edge as reference
    for (int m = 0; m < 6; m++)
      scenario("R3 R4 first-edge", 4'b1111, 4, 3, 5, 2, 16, 3, 1'b0, m, 1'b0, 0, 0);
    // R1: disabled links with earlier and later edges are ignored
    scenario("R1 mask last", 4'b0101, 4, 0, 1, 9, 16, 3, 1'b1, 2, 1'b0, 0, 2);
    scenario("R1 mask first", 4'b0101, 4, 0, 1, 9, 16, 3, 1'b0, 2, 1'b0, 0, 2);
    scenario("R1 single master", 4'b1000, 0, 1, 2, 6, 16, 3, 1'b1, 1, 1'b0, 0, 0);
    // R5: negative margin and clamp to zero
    scenario("R5 neg", 4'b1111, 1, 2, 3, 0, 20, 5, 1'b1, 4, 1'b1, 0, 0);
    scenario("R5 neg first", 4'b1111, 1, 2, 3, 0, 20, 5, 1'b0, 7, 1'b1, 0, 0);
    scenario("R5 clamp", 4'b1111, 1, 2, 3, 0, 20, 4, 1'b1, 25, 1'b1, 0, 0);
    // R6: divider sweep, positive and negative margin
    for (int d = 0; d < 4; d++)
      scenario("R6 div", 4'b1111, 0, 1, 2, 3, 12, 9, 1'b1, 1, 1'b0, d, 0);
    scenario("R6 div neg", 4'b0011, 0, 2, 0, 0, 12, 7, 1'b1, 3, 1'b1, 2, 0);
    // R7: threshold boundaries around a skew of 5
    scenario("R7 over", 4'b1111, 0, 3, 5, 2, 16, 3, 1'b1, 0, 1'b0, 0, 4);
    scenario("R7 equal", 4'b1111, 0, 3, 5, 2, 16, 3, 1'b1, 0, 1'b0, 0, 5);
    scenario("R7 zero skew", 4'b1111, 2, 2, 2, 2, 16, 3, 1'b1, 0, 1'b0, 0, 1);
    // R8: zero threshold with large skew
    scenario("R8 off", 4'b1111, 0, 9, 1, 1, 16, 3, 1'b1, 0, 1'b0, 0, 0);
    // R9: saturation
    scenario("R9 sat", 4'b1111, 0, 0, 0, 3, 8, 260, 1'b1, 0, 1'b0, 0, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule